// File: doc/BRIEF.md
# Region Protection Attribute Checker

This block guards and translates memory accesses for a core that has no paging unit. The 32-bit address space is divided into eight equal regions of 512 MB. The top three address bits select the region. Each region holds a three-bit physical region base and a four-bit attribute code. For each lookup, the checker takes a virtual address and an access kind (read, write or fetch). One cycle later it returns the physical address, the read/write/execute rights, the cache policy that the attribute selects, a grant flag and, when the access is refused, a fault cause.

A second mode bypasses translation. In this mode the physical address equals the virtual address. The attribute code comes from a packed 32-bit cache-attribute word, one nibble per region. The region table is loaded through a single-cycle write port that takes a region number, a base and an attribute.

Top module: `rgn_guard`

## Requirements
- R1: In translation mode the response address is the target region's base placed in bits 31:29, with bits 28:0 copied from the request address; the region number is request address bits 31:29.
- R2: After reset every region's base equals its own region number and its attribute is code 2.
- R3: Attribute decode, with cache field 0=bypass, 1=write-through, 2=write-back, 3=isolate: code 0 gives read+write, write-through; code 1 gives read+write+execute, write-through; code 2 gives read+write+execute, bypass; code 3 gives execute only, write-back; codes 4 and 5 give read+write+execute, write-back; code 14 gives read+write, isolate.
- R4: Every other attribute code gives no rights and a cache field of 0.
- R5: Access kind is 0=read, 1=write, 2=fetch, 3=reserved. A read needs the read right, a write needs the write right and a fetch needs the execute right. Kind 3 is never granted.
- R6: The fault cause is 0 when the access is granted. A refused access gives 1 for a read, 3 for a fetch, and 2 for a write or for kind 3. The grant flag is high exactly when the cause is 0.
- R7: When `xlat_off` is high, the response address equals the request address. The attribute is nibble `cache_attr[4*i+3:4*i]`, where i is the region number.
- R8: In the no-translation mode, code 5 gives no rights and a cache field of 0.
- R9: A lookup accepted on a rising edge is answered on the outputs after that same edge. `rsp_valid` follows `req_valid` with one cycle of delay.
- R10: A table write takes effect for lookups accepted on later edges. A lookup accepted on the same edge as a write to its region sees the old entry.
- R11: While `rsp_valid` is low, the address, rights, cache field, grant and cause outputs are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Region table write strobe |
| cfg_idx | input | 3 | Region number to write |
| cfg_base | input | 3 | New physical region base |
| cfg_attr | input | 4 | New attribute code |
| xlat_off | input | 1 | Selects the no-translation mode |
| cache_attr | input | 32 | Packed per-region attribute nibbles for the no-translation mode |
| req_valid | input | 1 | Lookup request |
| req_vaddr | input | 32 | Virtual address |
| req_kind | input | 2 | Access kind |
| rsp_valid | output | 1 | Response valid |
| rsp_paddr | output | 32 | Physical address |
| rsp_rd | output | 1 | Read right |
| rsp_wr | output | 1 | Write right |
| rsp_ex | output | 1 | Execute right |
| rsp_cache | output | 2 | Cache policy |
| rsp_grant | output | 1 | Access granted |
| rsp_cause | output | 2 | Fault cause |

## Verification
The table write and the lookup can act on the same region on the same clock edge. The bench provokes this by raising `cfg_we` and `req_valid` together, aimed at one region. It first performs a fetch there while rewriting the region to a code that has no execute right. It judges that the fetch is still granted with the old base and attribute. It then sends a second fetch on the next edge and expects it to be refused with the new attribute's fetch cause and the new base in the address.

// File: rtl/rgn_pkg.sv
package rgn_pkg;

  localparam int unsigned ATTR_W = 4;
  localparam logic [ATTR_W-1:0] ATTR_AT_RESET = 4'd2;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_kind_e;

  typedef enum logic [1:0] {
    CP_BYPASS  = 2'd0,
    CP_WTHRU   = 2'd1,
    CP_WBACK   = 2'd2,
    CP_ISOLATE = 2'd3
  } cache_pol_e;

  typedef enum logic [1:0] {
    FLT_NONE  = 2'd0,
    FLT_LOAD  = 2'd1,
    FLT_STORE = 2'd2,
    FLT_FETCH = 2'd3
  } fault_e;

  typedef struct packed {
    logic       rd;
    logic       wr;
    logic       ex;
    cache_pol_e pol;
  } rights_t;

  // Sparse attribute decode; codes without an entry grant nothing.
  function automatic rights_t decode_attr(input logic [ATTR_W-1:0] code,
                                          input logic notrans);
    rights_t r;
    r.rd  = 1'b0;
    r.wr  = 1'b0;
    r.ex  = 1'b0;
    r.pol = CP_BYPASS;
    case (code)
      4'd0: begin r.rd = 1'b1; r.wr = 1'b1; r.pol = CP_WTHRU; end
      4'd1: begin r.rd = 1'b1; r.wr = 1'b1; r.ex = 1'b1; r.pol = CP_WTHRU; end
      4'd2: begin r.rd = 1'b1; r.wr = 1'b1; r.ex = 1'b1; r.pol = CP_BYPASS; end
      4'd3: begin r.ex = 1'b1; r.pol = CP_WBACK; end
      4'd4: begin r.rd = 1'b1; r.wr = 1'b1; r.ex = 1'b1; r.pol = CP_WBACK; end
      4'd5: begin
        if (!notrans) begin
          r.rd = 1'b1; r.wr = 1'b1; r.ex = 1'b1; r.pol = CP_WBACK;
        end
      end
      4'd14: begin r.rd = 1'b1; r.wr = 1'b1; r.pol = CP_ISOLATE; end
      default: ;
    endcase
    return r;
  endfunction

  function automatic logic permits(input rights_t r, input acc_kind_e k);
    case (k)
      ACC_READ:  return r.rd;
      ACC_WRITE: return r.wr;
      ACC_FETCH: return r.ex;
      default:   return 1'b0;
    endcase
  endfunction

  function automatic fault_e deny_cause(input acc_kind_e k);
    case (k)
      ACC_READ:  return FLT_LOAD;
      ACC_FETCH: return FLT_FETCH;
      default:   return FLT_STORE;
    endcase
  endfunction

endpackage

// File: rtl/rgn_table.sv
module rgn_table
  import rgn_pkg::*;
#(
  parameter int unsigned IDX_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [IDX_W-1:0]  wr_base,
  input  logic [ATTR_W-1:0] wr_attr,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [IDX_W-1:0]  rd_base,
  output logic [ATTR_W-1:0] rd_attr
);

  localparam int unsigned NREG = 1 << IDX_W;

  logic [IDX_W-1:0]  base_arr [NREG];
  logic [ATTR_W-1:0] attr_arr [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    logic [IDX_W-1:0]  b_q;
    logic [ATTR_W-1:0] a_q;
    logic              hit;

    assign hit = we && (wr_idx == IDX_W'(i));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        b_q <= IDX_W'(i);
        a_q <= ATTR_AT_RESET;
      end else if (hit) begin
        b_q <= wr_base;
        a_q <= wr_attr;
      end
    end

    assign base_arr[i] = b_q;
    assign attr_arr[i] = a_q;
  end

  assign rd_base = base_arr[rd_idx];
  assign rd_attr = attr_arr[rd_idx];

endmodule

// File: rtl/rgn_attr_sel.sv
module rgn_attr_sel
  import rgn_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned IDX_W  = 3
) (
  input  logic                       xlat_off,
  input  logic [(ATTR_W<<IDX_W)-1:0] cache_attr,
  input  logic [ADDR_W-1:0]          vaddr,
  input  logic [IDX_W-1:0]           tbl_base,
  input  logic [ATTR_W-1:0]          tbl_attr,
  output logic [ATTR_W-1:0]          attr,
  output logic [ADDR_W-1:0]          paddr
);

  localparam int unsigned NREG  = 1 << IDX_W;
  localparam int unsigned OFS_W = ADDR_W - IDX_W;

  logic [ATTR_W-1:0] nib [NREG];
  logic [IDX_W-1:0]  idx;

  for (genvar i = 0; i < NREG; i++) begin : g_nib
    assign nib[i] = cache_attr[ATTR_W*i +: ATTR_W];
  end

  assign idx = vaddr[ADDR_W-1 -: IDX_W];

  always_comb begin
    if (xlat_off) begin
      attr  = nib[idx];
      paddr = vaddr;
    end else begin
      attr  = tbl_attr;
      paddr = {tbl_base, vaddr[OFS_W-1:0]};
    end
  end

endmodule

// File: rtl/rgn_resp_reg.sv
module rgn_resp_reg
  import rgn_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld,
  input  logic [ADDR_W-1:0] paddr_d,
  input  rights_t           rights_d,
  input  logic              ok_d,
  input  fault_e            cause_d,
  output logic              valid_q,
  output logic [ADDR_W-1:0] paddr_q,
  output rights_t           rights_q,
  output logic              ok_q,
  output fault_e            cause_q
);

  always_ff @(posedge clk) begin
    if (!rst_n || !ld) begin
      valid_q  <= 1'b0;
      paddr_q  <= '0;
      rights_q <= '0;
      ok_q     <= 1'b0;
      cause_q  <= FLT_NONE;
    end else begin
      valid_q  <= 1'b1;
      paddr_q  <= paddr_d;
      rights_q <= rights_d;
      ok_q     <= ok_d;
      cause_q  <= cause_d;
    end
  end

endmodule

// File: rtl/rgn_guard.sv
module rgn_guard
  import rgn_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned IDX_W  = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cfg_we,
  input  logic [IDX_W-1:0]           cfg_idx,
  input  logic [IDX_W-1:0]           cfg_base,
  input  logic [ATTR_W-1:0]          cfg_attr,
  input  logic                       xlat_off,
  input  logic [(ATTR_W<<IDX_W)-1:0] cache_attr,
  input  logic                       req_valid,
  input  logic [ADDR_W-1:0]          req_vaddr,
  input  logic [1:0]                 req_kind,
  output logic                       rsp_valid,
  output logic [ADDR_W-1:0]          rsp_paddr,
  output logic                       rsp_rd,
  output logic                       rsp_wr,
  output logic                       rsp_ex,
  output logic [1:0]                 rsp_cache,
  output logic                       rsp_grant,
  output logic [1:0]                 rsp_cause
);

  // Named internal events of the lookup path.
  logic [IDX_W-1:0]  lk_idx;
  logic [IDX_W-1:0]  lk_base;
  logic [ATTR_W-1:0] lk_tbl_attr;
  logic [ATTR_W-1:0] lk_attr;
  logic [ADDR_W-1:0] lk_paddr;
  rights_t           lk_rights;
  acc_kind_e         lk_kind;
  logic              lk_ok;
  fault_e            lk_cause;

  rights_t           q_rights;
  fault_e            q_cause;

  assign lk_idx  = req_vaddr[ADDR_W-1 -: IDX_W];
  assign lk_kind = acc_kind_e'(req_kind);

  rgn_table #(.IDX_W(IDX_W)) table_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (cfg_we),
    .wr_idx  (cfg_idx),
    .wr_base (cfg_base),
    .wr_attr (cfg_attr),
    .rd_idx  (lk_idx),
    .rd_base (lk_base),
    .rd_attr (lk_tbl_attr)
  );

  rgn_attr_sel #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) sel_i (
    .xlat_off   (xlat_off),
    .cache_attr (cache_attr),
    .vaddr      (req_vaddr),
    .tbl_base   (lk_base),
    .tbl_attr   (lk_tbl_attr),
    .attr       (lk_attr),
    .paddr      (lk_paddr)
  );

  assign lk_rights = decode_attr(lk_attr, xlat_off);
  assign lk_ok     = permits(lk_rights, lk_kind);
  assign lk_cause  = lk_ok ? FLT_NONE : deny_cause(lk_kind);

  rgn_resp_reg #(.ADDR_W(ADDR_W)) resp_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .ld       (req_valid),
    .paddr_d  (lk_paddr),
    .rights_d (lk_rights),
    .ok_d     (lk_ok),
    .cause_d  (lk_cause),
    .valid_q  (rsp_valid),
    .paddr_q  (rsp_paddr),
    .rights_q (q_rights),
    .ok_q     (rsp_grant),
    .cause_q  (q_cause)
  );

  assign rsp_rd    = q_rights.rd;
  assign rsp_wr    = q_rights.wr;
  assign rsp_ex    = q_rights.ex;
  assign rsp_cache = q_rights.pol;
  assign rsp_cause = q_cause;

endmodule

// File: rtl/rgn_guard_chk.sv
module rgn_guard_chk #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned IDX_W  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              xlat_off,
  input logic              req_valid,
  input logic [ADDR_W-1:0] req_vaddr,
  input logic [1:0]        req_kind,
  input logic              rsp_valid,
  input logic [ADDR_W-1:0] rsp_paddr,
  input logic              rsp_rd,
  input logic              rsp_wr,
  input logic              rsp_ex,
  input logic [1:0]        rsp_cache,
  input logic              rsp_grant,
  input logic [1:0]        rsp_cause
);

  localparam int unsigned OFS_W = ADDR_W - IDX_W;

  assert_valid_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  assert_idle_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> (!rsp_grant && rsp_cause == 2'd0 && !rsp_rd && !rsp_wr &&
                    !rsp_ex && rsp_cache == 2'd0 && rsp_paddr == '0));

  assert_offset_kept_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rsp_paddr[OFS_W-1:0] == $past(req_vaddr[OFS_W-1:0]));

  assert_passthru_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && $past(xlat_off)) |-> rsp_paddr == $past(req_vaddr));

  assert_grant_vs_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_grant == (rsp_cause == 2'd0)));

  assert_fetch_needs_ex_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_grant && $past(req_kind) == 2'd2) |-> rsp_ex);

  assert_rsvd_denied_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && $past(req_kind) == 2'd3) |-> (!rsp_grant && rsp_cause == 2'd2));

  assert_isolate_noexec_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_cache == 2'd3) |-> (!rsp_ex && rsp_rd && rsp_wr));

endmodule

bind rgn_guard rgn_guard_chk #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .xlat_off  (xlat_off),
  .req_valid (req_valid),
  .req_vaddr (req_vaddr),
  .req_kind  (req_kind),
  .rsp_valid (rsp_valid),
  .rsp_paddr (rsp_paddr),
  .rsp_rd    (rsp_rd),
  .rsp_wr    (rsp_wr),
  .rsp_ex    (rsp_ex),
  .rsp_cache (rsp_cache),
  .rsp_grant (rsp_grant),
  .rsp_cause (rsp_cause)
);

// File: tb/rgn_guard_tb.sv
module rgn_guard_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [2:0]  cfg_idx;
  logic [2:0]  cfg_base;
  logic [3:0]  cfg_attr;
  logic        xlat_off;
  logic [31:0] cache_attr;
  logic        req_valid;
  logic [31:0] req_vaddr;
  logic [1:0]  req_kind;
  logic        rsp_valid;
  logic [31:0] rsp_paddr;
  logic        rsp_rd, rsp_wr, rsp_ex;
  logic [1:0]  rsp_cache;
  logic        rsp_grant;
  logic [1:0]  rsp_cause;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  // Bench-side copy of the programmed table.
  logic [2:0] m_base [8];
  logic [3:0] m_attr [8];

  always #4 clk = ~clk;

  rgn_guard dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_base(cfg_base), .cfg_attr(cfg_attr), .xlat_off(xlat_off),
    .cache_attr(cache_attr), .req_valid(req_valid), .req_vaddr(req_vaddr),
    .req_kind(req_kind), .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr),
    .rsp_rd(rsp_rd), .rsp_wr(rsp_wr), .rsp_ex(rsp_ex), .rsp_cache(rsp_cache),
    .rsp_grant(rsp_grant), .rsp_cause(rsp_cause)
  );

  // {rd, wr, ex, cache[1:0]} per the requirement text.
  function automatic logic [4:0] model_rights(input logic [3:0] c, input bit nt);
    logic rd, wr, ex;
    logic [1:0] pol;
    bit five_ok;
    five_ok = (c == 4'd5) && !nt;
    rd  = (c inside {4'd0, 4'd1, 4'd2, 4'd4, 4'd14}) || five_ok;
    wr  = rd;
    ex  = (c inside {4'd1, 4'd2, 4'd3, 4'd4}) || five_ok;
    if (c == 4'd14)                             pol = 2'd3;
    else if (c == 4'd0 || c == 4'd1)            pol = 2'd1;
    else if (c == 4'd3 || c == 4'd4 || five_ok) pol = 2'd2;
    else                                        pol = 2'd0;
    return {rd, wr, ex, pol};
  endfunction

  function automatic logic [1:0] model_cause(input logic [4:0] r, input logic [1:0] k);
    bit ok;
    ok = (k == 2'd0) ? r[4] : (k == 2'd1) ? r[3] : (k == 2'd2) ? r[2] : 1'b0;
    if (ok) return 2'd0;
    if (k == 2'd0) return 2'd1;
    if (k == 2'd2) return 2'd3;
    return 2'd2;
  endfunction

  task automatic compare(input string rq, input logic [39:0] act, input logic [39:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  function automatic logic [39:0] pack_rsp();
    return {rsp_valid, rsp_paddr, rsp_rd, rsp_wr, rsp_ex, rsp_cache, rsp_grant, rsp_cause};
  endfunction

  function automatic logic [39:0] pack_exp(input logic [31:0] va, input logic [1:0] k,
                                           input bit nt, input logic [31:0] ca);
    logic [3:0]  c;
    logic [31:0] pa;
    logic [4:0]  r;
    logic [1:0]  cs;
    if (nt) begin
      c  = ca[va[31:29]*4 +: 4];
      pa = va;
    end else begin
      c  = m_attr[va[31:29]];
      pa = {m_base[va[31:29]], va[28:0]};
    end
    r  = model_rights(c, nt);
    cs = model_cause(r, k);
    return {1'b1, pa, r, (cs == 2'd0), cs};
  endfunction

  task automatic lookup(input string rq, input logic [31:0] va, input logic [1:0] k);
    logic [39:0] e;
    @(negedge clk);
    e = pack_exp(va, k, xlat_off, cache_attr);
    req_valid = 1'b1; req_vaddr = va; req_kind = k;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    compare(rq, pack_rsp(), e);
  endtask

  task automatic program_region(input logic [2:0] i, input logic [2:0] b, input logic [3:0] a);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = i; cfg_base = b; cfg_attr = a;
    @(posedge clk);
    @(negedge clk);
    cfg_we = 1'b0;
    m_base[i] = b; m_attr[i] = a;
  endtask

  task automatic t_reset_state();
    compare("R11 reset idle", pack_rsp(), 40'h0);
    for (int i = 0; i < 8; i++)
      for (int k = 0; k < 3; k++)
        lookup("R2 reset map", {i[2:0], 29'h0ABC_DE0 + 29'(i)}, k[1:0]);
  endtask

  task automatic t_translate();
    program_region(3'd5, 3'd1, 4'd3);
    lookup("R1 base swap fetch", 32'hA123_4567, 2'd2);
    lookup("R6 load cause", 32'hBFFF_FFFC, 2'd0);
    lookup("R6 store cause", 32'hA000_0000, 2'd1);
    lookup("R5 reserved kind", 32'hA000_0010, 2'd3);
  endtask

  task automatic t_all_codes();
    for (int c = 0; c < 16; c++) begin
      program_region(3'd2, 3'd6, c[3:0]);
      for (int k = 0; k < 4; k++)
        lookup((c inside {0,1,2,3,4,5,14}) ? "R3 code decode" : "R4 undefined code",
               32'h5555_0000 + 32'(c), k[1:0]);
    end
  endtask

  task automatic t_notrans();
    @(negedge clk);
    xlat_off   = 1'b1;
    cache_attr = 32'hE5F4_3210;  // regions 7..0: 14,5,15,4,3,2,1,0
    for (int i = 0; i < 8; i++)
      for (int k = 0; k < 3; k++)
        lookup((i == 6) ? "R8 code5 invalid" : "R7 nibble select",
               {i[2:0], 29'h1357_9BD}, k[1:0]);
    @(negedge clk);
    cache_attr = 32'h2222_2225;
    lookup("R8 code5 region0", 32'h0000_0040, 2'd0);
    @(negedge clk);
    xlat_off = 1'b0;
  endtask

  task automatic t_collision();
    logic [39:0] e_old;
    logic [39:0] e_new;
    program_region(3'd4, 3'd4, 4'd2);
    @(negedge clk);
    e_old = pack_exp(32'h8000_1000, 2'd2, 1'b0, cache_attr);
    cfg_we = 1'b1; cfg_idx = 3'd4; cfg_base = 3'd7; cfg_attr = 4'd0;
    req_valid = 1'b1; req_vaddr = 32'h8000_1000; req_kind = 2'd2;
    @(posedge clk);
    @(negedge clk);
    cfg_we = 1'b0;
    m_base[4] = 3'd7; m_attr[4] = 4'd0;
    e_new = pack_exp(32'h8000_1000, 2'd2, 1'b0, cache_attr);
    compare("R10 same-edge sees old", pack_rsp(), e_old);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    compare("R10 next edge sees new", pack_rsp(), e_new);
  endtask

  task automatic t_idle();
    @(negedge clk);
    req_valid = 1'b0; req_vaddr = 32'hFFFF_FFFF; req_kind = 2'd1;
    @(posedge clk);
    @(negedge clk);
    compare("R9 R11 idle outputs", pack_rsp(), 40'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_idx = '0; cfg_base = '0; cfg_attr = '0;
    xlat_off = 1'b0; cache_attr = '0; req_valid = 1'b0; req_vaddr = '0; req_kind = '0;
    for (int i = 0; i < 8; i++) begin
      m_base[i] = i[2:0];
      m_attr[i] = 4'd2;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset_state();
    t_translate();
    t_all_codes();
    t_notrans();
    t_collision();
    t_idle();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule